// File: doc/BRIEF.md
# Memory-to-Memory Byte Move Sequencer

This block carries out a single byte-move instruction for a small 8-bit processor core with a 16-bit address space. The core has already fetched the opcode byte at the current program counter. It hands that opcode, the program counter and the 16-bit index pair H:X to the sequencer with a one-cycle `start` pulse. The sequencer then fetches its operand bytes through a synchronous byte memory port, reads the source byte and writes it to the destination. It finishes with a one-cycle `done` pulse together with the new program counter and index value. The accumulator is never used. H:X is the only register value the block may return changed.

Four variants are supported. Two take two operand bytes: an immediate value to a zero-page location, and one zero-page location to another. Two take a single operand byte and step H:X by one afterwards: a read at H:X written to a zero-page location, and a zero-page read written at H:X. Zero-page means the first 256 bytes, so the upper address byte is $00. An unknown opcode ends at once with `err` and leaves the register values as they were.

The memory port is single-cycle. A read requested with `mem_rd` in one cycle returns `mem_rdata` in the next cycle. A write with `mem_wr` takes effect at the clock edge that ends the cycle. The state sequence is IDLE → OPA (fetch first operand) → OPB (capture it, fetch second operand for two-operand variants) → SRC (capture second operand, read source) → WR (write destination) → FIN (done) → IDLE. A bad opcode takes the path IDLE → FAULT → IDLE.

Top module: `byte_move_seq`

## Requirements
- R1: After reset `busy`, `done`, `err`, `mem_rd` and `mem_wr` are low, and `pc_out` and `hx_out` are zero.
- R2: Opcode $6E (immediate to zero page): the byte at PC+1 is the value and the byte at PC+2 is the zero-page destination address. The value is written there.
- R3: Opcode $4E (zero page to zero page): the byte at PC+1 is the zero-page source address and the byte at PC+2 is the zero-page destination address. The source byte is copied to the destination.
- R4: Opcode $7E (index to zero page): the byte at address H:X is copied to the zero-page address given by the byte at PC+1, and `hx_out` is H:X+1.
- R5: Opcode $5E (zero page to index): the byte at the zero-page address given by the byte at PC+1 is written at address H:X, and `hx_out` is H:X+1.
- R6: Every zero-page access, whether operand source or destination, uses the address {$00, byte}.
- R7: `pc_out` is PC+3 for $6E and $4E and PC+2 for $7E and $5E. `hx_out` equals H:X for $6E and $4E.
- R8: `done` is a one-cycle pulse in the fifth cycle after the cycle of the accepted `start`. Each move makes exactly one write. No read follows the write, and `mem_rd` and `mem_wr` are never both high. Reads number 3 for $4E and 2 for the other variants.
- R9: The source is read before the destination is written, so a move whose source and destination are the same address, or whose index address equals the zero-page operand address, gives the result of reading first.
- R10: Any other opcode at `start` raises `err` and `done` together for one cycle in the next cycle, makes no memory access, and returns `pc_out` and `hx_out` equal to the PC and H:X given with `start`.
- R11: A `start` pulse while `busy` is high, including the `done` cycle, is ignored. The move in progress completes unchanged and no second move begins.
- R12: H:X+1 wraps from $FFFF to $0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the move; taken only when idle |
| opcode | input | 8 | Already-fetched opcode byte |
| pc_in | input | 16 | Address of the opcode byte |
| hx_in | input | 16 | Current H:X index value |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unknown opcode; high together with `done` |
| pc_out | output | 16 | Program counter after the instruction |
| hx_out | output | 16 | H:X after the instruction |

## Verification
The completion cycle and a new `start` request can coincide, and so can a stray `start` in the middle of a move. The bench provokes both by pulsing `start` with a different opcode in the FIN cycle and in the OPB cycle. It judges the result by the results of the running move being unchanged, by `busy` falling and staying low, and by the absence of any further memory reads or writes. A second kind of coincidence is address overlap, where the source read and the destination write hit the same byte. Directed cases cover this, and the result is compared against a bench memory model that applies read-then-write order.

// File: rtl/mvseq_pkg.sv
package mvseq_pkg;

    typedef enum logic [1:0] {
        MK_IMM_ZP = 2'd0,
        MK_ZP_ZP  = 2'd1,
        MK_IDX_ZP = 2'd2,
        MK_ZP_IDX = 2'd3
    } mv_kind_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_OPA   = 3'd1,
        S_OPB   = 3'd2,
        S_SRC   = 3'd3,
        S_WR    = 3'd4,
        S_FIN   = 3'd5,
        S_FAULT = 3'd6
    } mv_state_e;

    typedef struct packed {
        logic     ok;
        mv_kind_e kind;
    } mv_dec_t;

    localparam logic [7:0] OPC_IMM_ZP = 8'h6E;
    localparam logic [7:0] OPC_ZP_ZP  = 8'h4E;
    localparam logic [7:0] OPC_IDX_ZP = 8'h7E;
    localparam logic [7:0] OPC_ZP_IDX = 8'h5E;

    function automatic logic has_two_operands(mv_kind_e k);
        return (k == MK_IMM_ZP) || (k == MK_ZP_ZP);
    endfunction

    function automatic logic steps_index(mv_kind_e k);
        return (k == MK_IDX_ZP) || (k == MK_ZP_IDX);
    endfunction

endpackage

// File: rtl/mvseq_decode.sv
module mvseq_decode
    import mvseq_pkg::*;
(
    input  logic [7:0] opcode,
    output mv_dec_t    dec
);
    always_comb begin
        dec.ok   = 1'b1;
        dec.kind = MK_IMM_ZP;
        unique case (opcode)
            OPC_IMM_ZP: dec.kind = MK_IMM_ZP;
            OPC_ZP_ZP:  dec.kind = MK_ZP_ZP;
            OPC_IDX_ZP: dec.kind = MK_IDX_ZP;
            OPC_ZP_IDX: dec.kind = MK_ZP_IDX;
            default:    dec.ok   = 1'b0;
        endcase
    end
endmodule

// File: rtl/mvseq_fsm.sv
module mvseq_fsm
    import mvseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      op_ok,
    output mv_state_e state,
    output logic      take,
    output logic      busy,
    output logic      done,
    output logic      err
);
    mv_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = op_ok ? S_OPA : S_FAULT;
            S_OPA:   nxt = S_OPB;
            S_OPB:   nxt = S_SRC;
            S_SRC:   nxt = S_WR;
            S_WR:    nxt = S_FIN;
            S_FIN:   nxt = S_IDLE;
            S_FAULT: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        take = (state == S_IDLE) && start;
        busy = (state != S_IDLE);
        done = (state == S_FIN) || (state == S_FAULT);
        err  = (state == S_FAULT);
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R10
    AST_OPA_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPA) |=> (state == S_OPB)); // R11
    AST_FIN_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FIN) |=> (state == S_IDLE)); // R11
endmodule

// File: rtl/mvseq_datapath.sv
module mvseq_datapath
    import mvseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mv_state_e     state,
    input  logic          take,
    input  mv_dec_t       dec,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] hx_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] hx_out
);
    localparam int HW = AW - DW;
    localparam logic [AW-1:0] STEP_LONG  = AW'(3);
    localparam logic [AW-1:0] STEP_SHORT = AW'(2);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] hx_q;
    mv_kind_e      kind_q;
    logic [DW-1:0] opnd1_q;
    logic [DW-1:0] opnd2_q;

    function automatic logic [AW-1:0] zpage(logic [DW-1:0] b);
        return {{HW{1'b0}}, b};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            hx_q    <= '0;
            kind_q  <= MK_IMM_ZP;
            opnd1_q <= '0;
            opnd2_q <= '0;
            pc_out  <= '0;
            hx_out  <= '0;
        end else begin
            if (take) begin
                pc_q   <= pc_in;
                hx_q   <= hx_in;
                kind_q <= dec.kind;
                if (!dec.ok) begin
                    pc_out <= pc_in;
                    hx_out <= hx_in;
                end
            end
            if (state == S_OPB) opnd1_q <= mem_rdata;
            if (state == S_SRC) opnd2_q <= mem_rdata;
            if (state == S_WR) begin
                pc_out <= pc_q + (has_two_operands(kind_q) ? STEP_LONG : STEP_SHORT);
                hx_out <= steps_index(kind_q) ? hx_q + AW'(1) : hx_q;
            end
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            S_OPA: begin
                mem_rd   = 1'b1;
                mem_addr = pc_q + AW'(1);
            end
            S_OPB: begin
                if (has_two_operands(kind_q)) begin
                    mem_rd   = 1'b1;
                    mem_addr = pc_q + AW'(2);
                end
            end
            S_SRC: begin
                unique case (kind_q)
                    MK_IMM_ZP: mem_rd = 1'b0;
                    MK_IDX_ZP: begin
                        mem_rd   = 1'b1;
                        mem_addr = hx_q;
                    end
                    default: begin
                        mem_rd   = 1'b1;
                        mem_addr = zpage(opnd1_q);
                    end
                endcase
            end
            S_WR: begin
                mem_wr    = 1'b1;
                mem_wdata = (kind_q == MK_IMM_ZP) ? opnd1_q : mem_rdata;
                unique case (kind_q)
                    MK_IMM_ZP, MK_ZP_ZP: mem_addr = zpage(opnd2_q);
                    MK_IDX_ZP:           mem_addr = zpage(opnd1_q);
                    default:             mem_addr = hx_q;
                endcase
            end
            default: ;
        endcase
    end

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R8
    AST_ZP_DEST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && kind_q != MK_ZP_IDX) |-> (mem_addr[AW-1:DW] == '0)); // R6
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FAULT) |-> (!mem_rd && !mem_wr)); // R10
    AST_FAULT_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FAULT) |-> (pc_out == $past(pc_in) && hx_out == $past(hx_in))); // R10
    AST_HX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FIN && !steps_index(kind_q)) |-> (hx_out == hx_q)); // R7
    AST_OPND_STABLE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR) |-> $stable(opnd1_q)); // R9
endmodule

// File: rtl/byte_move_seq.sv
module byte_move_seq
    import mvseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] hx_in,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] hx_out
);
    mv_dec_t   dec;
    mv_state_e state;
    logic      take;

    mvseq_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    mvseq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .op_ok (dec.ok),
        .state (state),
        .take  (take),
        .busy  (busy),
        .done  (done),
        .err   (err)
    );

    mvseq_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .take      (take),
        .dec       (dec),
        .pc_in     (pc_in),
        .hx_in     (hx_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .pc_out    (pc_out),
        .hx_out    (hx_out)
    );
endmodule

// File: tb/byte_move_seq_test.sv
module byte_move_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 10;
    localparam int MSIZE = 1 << MW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc_in = 16'h0;
    logic [15:0] hx_in = 16'h0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic        busy, done, err;
    logic [15:0] pc_out, hx_out;

    logic [7:0]  mem [MSIZE];
    logic [7:0]  shadow [MSIZE];
    logic        wipe = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_a = 16'h0;
    logic [7:0]  ld_d = 8'h0;
    logic        mon_clr = 1'b0;
    int          rd_cnt, wr_cnt, rd_after_wr;
    int          n_chk = 0;
    int          n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_move_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .pc_in(pc_in), .hx_in(hx_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .err(err),
        .pc_out(pc_out), .hx_out(hx_out)
    );

    function automatic logic [7:0] fill_pat(int i);
        return 8'(i * 37 + 11);
    endfunction

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[MW-1:0]];
        if (wipe) begin
            for (int i = 0; i < MSIZE; i++) mem[i] <= fill_pat(i);
        end else if (mem_wr) begin
            mem[mem_addr[MW-1:0]] <= mem_wdata;
        end else if (ld_en) begin
            mem[ld_a[MW-1:0]] <= ld_d;
        end
    end

    always @(posedge clk) begin
        if (mon_clr) begin
            rd_cnt = 0; wr_cnt = 0; rd_after_wr = 0;
        end else begin
            if (mem_rd) begin
                rd_cnt++;
                if (wr_cnt > 0) rd_after_wr++;
            end
            if (mem_wr) wr_cnt++;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ld(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk);
        ld_en = 1'b0;
        shadow[a[MW-1:0]] = d;
    endtask

    function automatic logic valid_op(logic [7:0] op);
        return op == 8'h6E || op == 8'h4E || op == 8'h7E || op == 8'h5E;
    endfunction

    function automatic logic [15:0] zp(logic [7:0] b);
        return {8'h00, b};
    endfunction

    function automatic logic [15:0] exp_pc(logic [7:0] op, logic [15:0] pc);
        return (op == 8'h6E || op == 8'h4E) ? pc + 16'd3 : pc + 16'd2;
    endfunction

    function automatic logic [15:0] exp_hx(logic [7:0] op, logic [15:0] hx);
        return (op == 8'h7E || op == 8'h5E) ? hx + 16'd1 : hx;
    endfunction

    function automatic int exp_reads(logic [7:0] op);
        return (op == 8'h4E) ? 3 : 2;
    endfunction

    // stray: 0 none, 1 start during OPB, 2 start in done cycle
    task automatic run_move(input logic [7:0] op, input logic [15:0] pc, input logic [15:0] hx,
                            input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] sv,
                            input int stray, input string req);
        logic [7:0] e1, e2, val;
        logic [15:0] src, dst;
        ld(pc + 16'd1, b1);
        ld(pc + 16'd2, b2);
        if (op == 8'h7E) ld(hx, sv);
        else if (op != 8'h6E) ld(zp(b1), sv);
        e1 = shadow[(pc + 16'd1) & 16'(MSIZE-1)];
        e2 = shadow[(pc + 16'd2) & 16'(MSIZE-1)];
        case (op)
            8'h6E: begin src = 16'h0; dst = zp(e2); end
            8'h4E: begin src = zp(e1); dst = zp(e2); end
            8'h7E: begin src = hx; dst = zp(e1); end
            default: begin src = zp(e1); dst = hx; end
        endcase
        val = (op == 8'h6E) ? e1 : shadow[src[MW-1:0]];
        shadow[dst[MW-1:0]] = val;

        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        opcode = op; pc_in = pc; hx_in = hx; start = 1'b1;
        @(negedge clk); start = 1'b0;                          // cycle 1 (OPA)
        @(negedge clk);                                        // cycle 2 (OPB)
        if (stray == 1) begin
            opcode = 8'h6E; pc_in = ~pc; hx_in = ~hx; start = 1'b1;
        end
        @(negedge clk); start = 1'b0;                          // cycle 3
        chk(busy === 1'b1, "R11 busy mid-move", busy, 1);
        @(negedge clk);                                        // cycle 4
        chk(done === 1'b0, "R8 done early", done, 0);
        @(negedge clk);                                        // cycle 5 (FIN)
        chk(done === 1'b1, {req, " R8 done timing"}, done, 1);
        chk(err === 1'b0, {req, " R8 err"}, err, 0);
        chk(pc_out === exp_pc(op, pc), {req, " R7 pc_out"}, pc_out, exp_pc(op, pc));
        chk(hx_out === exp_hx(op, hx), {req, " R7 hx_out"}, hx_out, exp_hx(op, hx));
        if (stray == 2) begin
            opcode = 8'h4E; pc_in = 16'h0300; start = 1'b1;
        end
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b0 && done === 1'b0, "R11 idle after done", {busy, done}, 0);
        @(negedge clk);
        chk(busy === 1'b0, "R11 stays idle", busy, 0);
        chk(wr_cnt == 1, {req, " R8 write count"}, wr_cnt, 1);
        chk(rd_cnt == exp_reads(op), {req, " R8 read count"}, rd_cnt, exp_reads(op));
        chk(rd_after_wr == 0, "R9 no read after write", rd_after_wr, 0);
        chk(mem[dst[MW-1:0]] === val, {req, " moved byte"}, mem[dst[MW-1:0]], val);
        begin
            int diffs = 0;
            for (int i = 0; i < MSIZE; i++) if (mem[i] !== shadow[i]) diffs++;
            chk(diffs == 0, {req, " R9 memory image"}, diffs, 0);
        end
    endtask

    task automatic run_bad(input logic [7:0] op, input logic [15:0] pc, input logic [15:0] hx);
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
        opcode = op; pc_in = pc; hx_in = hx; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(err === 1'b1 && done === 1'b1, "R10 err+done", {err, done}, 3);
        chk(pc_out === pc, "R10 pc kept", pc_out, pc);
        chk(hx_out === hx, "R10 hx kept", hx_out, hx);
        @(negedge clk);
        chk(err === 1'b0 && busy === 1'b0, "R10 err one cycle", {err, busy}, 0);
        chk(rd_cnt == 0 && wr_cnt == 0, "R10 no memory access", rd_cnt + wr_cnt, 0);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        for (int i = 0; i < MSIZE; i++) shadow[i] = fill_pat(i);
        repeat (3) @(negedge clk);
        chk(busy === 0 && done === 0 && err === 0, "R1 reset flags", {busy, done, err}, 0);
        chk(mem_rd === 0 && mem_wr === 0, "R1 reset memory strobes", {mem_rd, mem_wr}, 0);
        chk(pc_out === 16'h0 && hx_out === 16'h0, "R1 reset registers", pc_out ^ hx_out, 0);
        rst_n = 1'b1;
        wipe = 1'b1;
        @(negedge clk); wipe = 1'b0;

        run_move(8'h6E, 16'h0210, 16'h1234, 8'hAA, 8'hF0, 8'h00, 0, "R2 imm");
        run_move(8'h4E, 16'h0220, 16'h4321, 8'h05, 8'hC3, 8'h77, 0, "R3 zp-zp");
        run_move(8'h7E, 16'h0230, 16'h0380, 8'h18, 8'h00, 8'h50, 0, "R4 idx-zp");
        run_move(8'h5E, 16'h0240, 16'h03A0, 8'h18, 8'h00, 8'h61, 0, "R5 zp-idx");
        run_move(8'h4E, 16'h0250, 16'hAB00, 8'h40, 8'h40, 8'h3C, 0, "R9 same addr");
        run_move(8'h7E, 16'h0260, 16'h0033, 8'h33, 8'h00, 8'h9E, 0, "R9 idx=zp");
        run_move(8'h5E, 16'h0270, 16'h0044, 8'h44, 8'h00, 8'h1D, 0, "R9 zp=idx");
        run_move(8'h7E, 16'h0280, 16'hFFFF, 8'h60, 8'h00, 8'hE1, 0, "R12 wrap");
        run_move(8'h5E, 16'h0290, 16'hFFFF, 8'h61, 8'h00, 8'h2B, 0, "R12 wrap");
        run_move(8'h6E, 16'hFFFE, 16'h0000, 8'h5A, 8'h70, 8'h00, 0, "R7 pc wrap");
        run_move(8'h4E, 16'h02A0, 16'h0000, 8'h10, 8'h90, 8'h44, 1, "R11 stray mid");
        run_move(8'h7E, 16'h02B0, 16'h0391, 8'h92, 8'h00, 8'h88, 2, "R11 stray at done");
        run_move(8'h6E, 16'h02C0, 16'h0101, 8'hC6, 8'hFF, 8'h00, 0, "R6 top zp");
        run_bad(8'h9D, 16'h0345, 16'hBEEF);
        run_bad(8'h6F, 16'hFFFF, 16'h0001);

        for (int t = 0; t < 160; t++) begin
            logic [7:0] op;
            int sel = $urandom_range(0, 9);
            op = (sel < 3) ? 8'h6E : (sel < 5) ? 8'h4E : (sel < 7) ? 8'h7E : (sel < 9) ? 8'h5E : 8'h00;
            if (op == 8'h00) begin
                do op = 8'($urandom); while (valid_op(op));
                run_bad(op, 16'($urandom), 16'($urandom));
            end else begin
                run_move(op, 16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                         8'($urandom), $urandom_range(0, 2), "R6 random");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule